// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox Registers

This block holds a parameterised number of mailboxes that two software agents use to pass short messages and raise doorbell interrupts at each other. Every mailbox has two identical doorbell channels: one that signals toward the agent that posts messages, and one that signals toward the agent that consumes them. Each mailbox also has two 32-bit message words. A typical exchange goes like this. The poster fills the message words and rings the consumer's doorbell. The consumer takes an interrupt, or polls the status bit, and reads the words. It may then ring the poster's doorbell to acknowledge.

All registers sit behind one simple memory-mapped port. A request is presented for a single cycle with an address, a write enable, write data and byte strobes. One cycle later the block answers with a one-cycle ready pulse and, for reads, the read data. There is no access protection: any requester may read or write any register of any mailbox. Each doorbell channel drives its own level-sensitive interrupt output, gated by that channel's enable bit.

Top module: `mbox_bank`

## Requirements
- R1: Mailbox b occupies byte addresses b*0x100 to b*0x100+0xFF. The register offsets within that window are:
  - posting-side doorbell: status 0x00, set 0x04, clear 0x08, enable 0x0C;
  - consuming-side doorbell: status 0x40, set 0x44, clear 0x48, enable 0x4C;
  - message word A at 0x80, message word B at 0x8C.

  Status and enable read back in bit 0, with bits 31:1 as 0.
- R2: A write to a set register with be_i[0]=1 and wdata_i[0]=1 makes that channel's status 1. The same kind of write to a clear register makes it 0. Any other write to set or clear, whether wdata_i[0]=0 or be_i[0]=0, leaves the status unchanged.
- R3: Each interrupt output equals its channel's status AND its enable bit, taken from a register. It changes in the cycle that follows the clock edge on which the causing write is accepted.
- R4: Status can be read while enable is 0. In that case the status reads 1 after a set, and the interrupt output stays 0.
- R5: Set and clear registers read as 0. Writes to a status register are ignored.
- R6: The enable bits and message words are plain read/write storage. A write to enable takes wdata_i[0] when be_i[0]=1. For a message word, byte strobe be_i[k] gates bits 8k+7 down to 8k, and unstrobed bytes keep their old value.
- R7: After reset, every status, enable and message bit is 0, every interrupt output is 0 and ready_o is 0.
- R8: An access is unmapped if it has a mailbox index (addr_i[ADDR_W-1:8]) of NUM_BOX or above, an offset not listed in R1, or addr_i[1:0] not equal to 0. An unmapped read returns 0, and an unmapped write changes no state.
- R9: ready_o is high in exactly the cycle after each cycle with req_i=1, and low otherwise. rdata_o carries the read data in that cycle, and is 0 for writes.
- R10: A write changes only the channel or message word it addresses. Every other channel and word, in the same mailbox and in other mailboxes, is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte strobes for writes |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | One-cycle completion pulse |
| snd_irq_o | output | NUM_BOX | Posting-side doorbell interrupts, one per mailbox |
| rcv_irq_o | output | NUM_BOX | Consuming-side doorbell interrupts, one per mailbox |

## Verification
The hardest case to reach from the ports is a write that looks close to a real register hit but must still change nothing. Examples are a set with the strobe off or with data bit 0 clear, a write to a status register, a misaligned address, and an index just above the last mailbox. In each of these cases the interrupt pins and every stored bit must stay untouched. The random stimulus draws mailbox indices beyond NUM_BOX, offsets from both the mapped list and arbitrary values, and independent strobes and data. A bench model predicts every read and all 2*NUM_BOX interrupt pins after each access. Directed sequences also cover polling with the enable off and the exact cycle in which an interrupt rises.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;

    localparam logic [7:0] OFF_S_STAT = 8'h00;
    localparam logic [7:0] OFF_S_SET  = 8'h04;
    localparam logic [7:0] OFF_S_CLR  = 8'h08;
    localparam logic [7:0] OFF_S_EN   = 8'h0C;
    localparam logic [7:0] OFF_R_STAT = 8'h40;
    localparam logic [7:0] OFF_R_SET  = 8'h44;
    localparam logic [7:0] OFF_R_CLR  = 8'h48;
    localparam logic [7:0] OFF_R_EN   = 8'h4C;
    localparam logic [7:0] OFF_MSG_A  = 8'h80;
    localparam logic [7:0] OFF_MSG_B  = 8'h8C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_S_STAT, SEL_S_SET, SEL_S_CLR, SEL_S_EN,
        SEL_R_STAT, SEL_R_SET, SEL_R_CLR, SEL_R_EN,
        SEL_MSG_A, SEL_MSG_B
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic en;
        logic irq;
    } chan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word_a;
        logic [WORD_W-1:0] word_b;
    } msg_state_t;

    typedef struct packed {
        logic              ready;
        logic [WORD_W-1:0] rdata;
    } port_state_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] res;
        for (int k = 0; k < BE_W; k++) begin
            res[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = ADDR_W - 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  box_idx_o,
    output logic              box_hit_o,
    output reg_sel_e          sel_o
);

    always_comb begin
        box_idx_o = addr_i[ADDR_W-1:8];
        box_hit_o = (int'(box_idx_o) < NUM_BOX);
        case (addr_i[7:0])
            OFF_S_STAT: sel_o = SEL_S_STAT;
            OFF_S_SET:  sel_o = SEL_S_SET;
            OFF_S_CLR:  sel_o = SEL_S_CLR;
            OFF_S_EN:   sel_o = SEL_S_EN;
            OFF_R_STAT: sel_o = SEL_R_STAT;
            OFF_R_SET:  sel_o = SEL_R_SET;
            OFF_R_CLR:  sel_o = SEL_R_CLR;
            OFF_R_EN:   sel_o = SEL_R_EN;
            OFF_MSG_A:  sel_o = SEL_MSG_A;
            OFF_MSG_B:  sel_o = SEL_MSG_B;
            default:    sel_o = SEL_NONE;
        endcase
        if (!box_hit_o) begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
    import mbox_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_we_i,
    input  logic en_val_i,
    output logic stat_o,
    output logic en_o,
    output logic irq_o
);

    chan_state_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (set_i) begin
            ch_d.stat = 1'b1;
        end
        if (clr_i) begin
            ch_d.stat = 1'b0;
        end
        if (en_we_i) begin
            ch_d.en = en_val_i;
        end
        ch_d.irq = ch_d.stat & ch_d.en;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign stat_o = ch_q.stat;
    assign en_o   = ch_q.en;
    assign irq_o  = ch_q.irq;

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i && !clr_i |=> stat_o); // R2
    AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !stat_o); // R2
    AST_STAT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !set_i && !clr_i |=> $stable(stat_o)); // R2
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |-> !irq_o); // R3
    AST_POLL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_we_i && !en_val_i) |=> !irq_o); // R4

endmodule

// File: rtl/mbox_msg.sv
module mbox_msg
    import mbox_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_a_i,
    input  logic              we_b_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o
);

    msg_state_t msg_d, msg_q;

    always_comb begin
        msg_d = msg_q;
        if (we_a_i) begin
            msg_d.word_a = merge_bytes(msg_q.word_a, wdata_i, be_i);
        end
        if (we_b_i) begin
            msg_d.word_b = merge_bytes(msg_q.word_b, wdata_i, be_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            msg_q <= '0;
        end else begin
            msg_q <= msg_d;
        end
    end

    assign word_a_o = msg_q.word_a;
    assign word_b_o = msg_q.word_b;

    AST_MSG_A_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_a_i |=> $stable(word_a_o)); // R10
    AST_MSG_B_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_b_i |=> $stable(word_b_o)); // R10
    AST_MSG_LOW_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_a_i && !be_i[0] |=> word_a_o[7:0] == $past(word_a_o[7:0])); // R6

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NUM_BOX = 4,
    parameter int ADDR_W  = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_i,
    output logic [31:0]       rdata_o,
    output logic              ready_o,
    output logic [NUM_BOX-1:0] snd_irq_o,
    output logic [NUM_BOX-1:0] rcv_irq_o
);

    localparam int IDX_W = ADDR_W - 8;

    logic [IDX_W-1:0] box_idx;
    logic             box_hit;
    reg_sel_e         sel;

    mbox_decode #(.NUM_BOX(NUM_BOX), .ADDR_W(ADDR_W)) u_decode (
        .addr_i    (addr_i),
        .box_idx_o (box_idx),
        .box_hit_o (box_hit),
        .sel_o     (sel)
    );

    logic acc_wr, acc_rd, bit_wr, bit_one;
    assign acc_wr  = req_i && we_i;
    assign acc_rd  = req_i && !we_i;
    assign bit_wr  = acc_wr && be_i[0];
    assign bit_one = bit_wr && wdata_i[0];

    logic [NUM_BOX-1:0] box_sel;
    logic [NUM_BOX-1:0] s_stat, s_en, r_stat, r_en;
    logic [WORD_W-1:0]  word_a [NUM_BOX];
    logic [WORD_W-1:0]  word_b [NUM_BOX];

    for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
        assign box_sel[g] = box_hit && (box_idx == IDX_W'(g));

        mbox_channel u_snd (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .set_i    (bit_one && box_sel[g] && sel == SEL_S_SET),
            .clr_i    (bit_one && box_sel[g] && sel == SEL_S_CLR),
            .en_we_i  (bit_wr && box_sel[g] && sel == SEL_S_EN),
            .en_val_i (wdata_i[0]),
            .stat_o   (s_stat[g]),
            .en_o     (s_en[g]),
            .irq_o    (snd_irq_o[g])
        );

        mbox_channel u_rcv (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .set_i    (bit_one && box_sel[g] && sel == SEL_R_SET),
            .clr_i    (bit_one && box_sel[g] && sel == SEL_R_CLR),
            .en_we_i  (bit_wr && box_sel[g] && sel == SEL_R_EN),
            .en_val_i (wdata_i[0]),
            .stat_o   (r_stat[g]),
            .en_o     (r_en[g]),
            .irq_o    (rcv_irq_o[g])
        );

        mbox_msg u_msg (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .we_a_i   (acc_wr && box_sel[g] && sel == SEL_MSG_A),
            .we_b_i   (acc_wr && box_sel[g] && sel == SEL_MSG_B),
            .wdata_i  (wdata_i),
            .be_i     (be_i),
            .word_a_o (word_a[g]),
            .word_b_o (word_b[g])
        );
    end

    port_state_t port_d, port_q;
    logic [WORD_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NUM_BOX; b++) begin
            if (box_sel[b]) begin
                case (sel)
                    SEL_S_STAT: rd_val = {31'd0, s_stat[b]};
                    SEL_S_EN:   rd_val = {31'd0, s_en[b]};
                    SEL_R_STAT: rd_val = {31'd0, r_stat[b]};
                    SEL_R_EN:   rd_val = {31'd0, r_en[b]};
                    SEL_MSG_A:  rd_val = word_a[b];
                    SEL_MSG_B:  rd_val = word_b[b];
                    default:    rd_val = '0;
                endcase
            end
        end
        port_d.ready = req_i;
        port_d.rdata = acc_rd ? rd_val : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign ready_o = port_q.ready;
    assign rdata_o = port_q.rdata;

    AST_READY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> ready_o); // R9
    AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !ready_o); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_rd && !box_hit |=> rdata_o == '0); // R8
    AST_SET_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_rd && (sel == SEL_S_SET || sel == SEL_R_CLR) |=> rdata_o == '0); // R5
    AST_WRITE_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_wr |=> rdata_o == '0); // R9

endmodule

// File: tb/tb_mbox_bank.sv
`timescale 1ns/1ps
module tb_mbox_bank;

    localparam int NB = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    be = '0;
    logic [31:0]   rdata;
    logic          ready;
    logic [NB-1:0] snd_irq, rcv_irq;

    always #2.5 clk = ~clk;

    mbox_bank #(.NUM_BOX(NB), .ADDR_W(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .ready_o(ready),
        .snd_irq_o(snd_irq), .rcv_irq_o(rcv_irq)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic m_ss [NB], m_se [NB], m_rs [NB], m_re [NB];
    logic [31:0] m_a [NB], m_b [NB];

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = s[k] ? n[8*k +: 8] : o[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        int bx = int'(a[AW-1:8]);
        if (bx >= NB) return 32'd0;
        case (a[7:0])
            8'h00: return {31'd0, m_ss[bx]};
            8'h0C: return {31'd0, m_se[bx]};
            8'h40: return {31'd0, m_rs[bx]};
            8'h4C: return {31'd0, m_re[bx]};
            8'h80: return m_a[bx];
            8'h8C: return m_b[bx];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        int bx = int'(a[AW-1:8]);
        logic one = s[0] && d[0];
        if (bx >= NB) return;
        case (a[7:0])
            8'h04: if (one) m_ss[bx] = 1'b1;
            8'h08: if (one) m_ss[bx] = 1'b0;
            8'h0C: if (s[0]) m_se[bx] = d[0];
            8'h44: if (one) m_rs[bx] = 1'b1;
            8'h48: if (one) m_rs[bx] = 1'b0;
            8'h4C: if (s[0]) m_re[bx] = d[0];
            8'h80: m_a[bx] = mrg(m_a[bx], d, s);
            8'h8C: m_b[bx] = mrg(m_b[bx], d, s);
            default: ;
        endcase
    endtask

    task automatic chk_irq(input string rq);
        logic [NB-1:0] es, er;
        for (int b = 0; b < NB; b++) begin
            es[b] = m_ss[b] & m_se[b];
            er[b] = m_rs[b] & m_re[b];
        end
        chk({rq, " snd_irq"}, 32'(snd_irq), 32'(es));
        chk({rq, " rcv_irq"}, 32'(rcv_irq), 32'(er));
    endtask

    // One access: drive at a falling edge, response sampled at the next falling edge.
    task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [3:0] s, output logic [31:0] rd);
        logic [31:0] ex;
        @(negedge clk);
        chk("R9 ready idle", 32'(ready), 32'd0);
        chk_irq("R3 before edge");
        req = 1'b1; we = w; addr = a; wdata = d; be = s;
        ex = w ? 32'd0 : exp_read(a);
        if (w) model_write(a, d, s);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata;
        chk("R9 ready pulse", 32'(ready), 32'd1);
        chk("R1/R8 rdata", rdata, ex);
        chk_irq("R3 after edge");
    endtask

    function automatic logic [AW-1:0] ad(input int bx, input logic [7:0] off);
        return {bx[AW-9:0], off};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h8C};
        void'($urandom(32'd4242));
        for (int b = 0; b < NB; b++) begin
            m_ss[b] = 0; m_se[b] = 0; m_rs[b] = 0; m_re[b] = 0; m_a[b] = 0; m_b[b] = 0;
        end
        repeat (3) @(negedge clk);
        chk("R7 reset ready", 32'(ready), 32'd0);
        chk("R7 reset irq", 32'({snd_irq, rcv_irq}), 32'd0);
        rst_n = 1'b1;

        // R7: every register of every mailbox reads 0 after reset
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 10; k++) access(0, ad(b, offs[k]), 0, 4'hF, r);

        // R4: poll with enable off
        access(1, ad(0, 8'h44), 32'h1, 4'h1, r);
        access(0, ad(0, 8'h40), 0, 0, r);
        chk("R4 stat polled", r, 32'd1);
        chk("R4 irq quiet", 32'(rcv_irq[0]), 32'd0);
        // R3: enabling raises the line one cycle later (checked inside access)
        access(1, ad(0, 8'h4C), 32'h1, 4'h1, r);
        chk("R3 irq high", 32'(rcv_irq[0]), 32'd1);
        chk("R10 snd untouched", 32'(snd_irq[0]), 32'd0);
        // R2: zero data and missing strobe have no effect
        access(1, ad(0, 8'h48), 32'h0, 4'hF, r);
        chk("R2 clr zero ignored", 32'(rcv_irq[0]), 32'd1);
        access(1, ad(0, 8'h48), 32'h1, 4'hE, r);
        chk("R2 clr no strobe ignored", 32'(rcv_irq[0]), 32'd1);
        // R5: set/clear read 0, status write ignored
        access(0, ad(0, 8'h44), 0, 0, r);
        chk("R5 set reads 0", r, 32'd0);
        access(1, ad(0, 8'h40), 32'h0, 4'hF, r);
        access(0, ad(0, 8'h40), 0, 0, r);
        chk("R5 stat write ignored", r, 32'd1);
        access(1, ad(0, 8'h48), 32'h1, 4'h1, r);
        chk("R2 clr takes", 32'(rcv_irq[0]), 32'd0);
        // R6: byte strobes on message words
        access(1, ad(2, 8'h80), 32'hAABBCCDD, 4'hF, r);
        access(1, ad(2, 8'h80), 32'h11223344, 4'h5, r);
        access(0, ad(2, 8'h80), 0, 0, r);
        chk("R6 byte merge", r, 32'hAA22CC44);
        // R8: out-of-range index, misaligned, hole
        access(1, ad(NB, 8'h80), 32'hFFFFFFFF, 4'hF, r);
        access(1, ad(1, 8'h81), 32'hFFFFFFFF, 4'hF, r);
        access(1, ad(1, 8'h10), 32'hFFFFFFFF, 4'hF, r);
        access(1, ad(3, 8'h05), 32'h1, 4'h1, r);
        access(0, ad(1, 8'h80), 0, 0, r);
        chk("R8 misaligned write ignored", r, 32'd0);
        access(0, ad(NB+1, 8'h00), 0, 0, r);
        chk("R8 high index reads 0", r, 32'd0);

        // Random mix; R1, R3, R10 checked by model inside access
        for (int i = 0; i < 4000; i++) begin
            int bx = int'($urandom_range(0, NB + 1));
            logic [7:0] off = ($urandom_range(0, 7) == 0) ? 8'($urandom) : offs[$urandom_range(0, 9)];
            logic w = ($urandom_range(0, 2) != 0);
            logic [31:0] d = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 1)) : $urandom;
            logic [3:0] s = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF;
            access(w, ad(bx, off), d, s, r);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule